// File: doc/BRIEF.md
# Segment LCD Multiplex Scan Timer

This block sequences the drive of a multiplexed segment LCD with 8 common lines and 64 segment lines, up to 512 pixels. It runs from a 32.768 kHz clock. That clock is divided into eight common slots of 64 clocks each, which gives a 64 Hz frame. For every pin the block produces a 3-bit code that selects one of five drive levels: ground, 1/4, 2/4, 3/4 and full. A separate analog stage turns these codes into voltages.

Pixel data arrive on a flat bus made of one 8-bit column per segment. Bit n of a column is the pixel at common n. The row for the coming common is captured at the start of each slot, so the host may rewrite the display memory at any time without corrupting a slot in progress. On alternate frames every level is mirrored around mid-scale, which keeps the average voltage across each pixel at zero. A display-enable input forces every pin to ground while it is low. A one-cycle frame marker lets surrounding logic align with the scan.

Top module: `lcd_mux_scan`

## Requirements
- R1: While reset is asserted, every common and segment code is 0 (ground) and `frame_start` is 0.
- R2: All drive codes are refreshed on the first clock edge after reset release and then once every 64 clocks. Successive refreshes serve commons 0, 1, …, 7 in order, and then the sequence wraps, so one frame is 512 clocks.
- R3: In a non-inverted frame, the common being served is driven with code 4 (full) and every other common with code 1 (1/4).
- R4: In a non-inverted frame, segment k is driven with code 0 when its pixel is on and code 2 when it is off. The pixel is bit `k*8+n` of `seg_cols` while common n is served.
- R5: Pixel data is sampled only at a slot refresh. Changes to `seg_cols` in the middle of a slot leave the outputs unchanged until the next refresh.
- R6: Frames alternate between non-inverted and inverted, and the first frame after reset is non-inverted. In an inverted frame each code c becomes 4−c: the served common is 0, other commons are 3, pixels that are on are 4 and pixels that are off are 2.
- R7: When `disp_on` is low at a clock edge, every code is 0 from that edge on. Slot timing keeps running. After `disp_on` returns high, driving resumes at the next slot refresh.
- R8: `frame_start` is high for exactly one cycle, together with the refresh that serves common 0 in a non-inverted frame. It stays low on every other cycle and while the display is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz scan clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| disp_on | input | 1 | Display enable; low forces all codes to ground |
| seg_cols | input | 512 | Pixel memory, 8-bit column per segment, bit n = common n |
| com_lvl | output | 24 | 3-bit drive code per common, common n at [3n+2:3n] |
| seg_lvl | output | 192 | 3-bit drive code per segment, segment k at [3k+2:3k] |
| frame_start | output | 1 | One-cycle marker at the start of a non-inverted frame |

## Verification
A refresh registered at edge 1+64·s becomes visible right after that edge. The bench counts edges from reset release, queues the expected codes for slot s with due edge 1+64·s, and compares them at the following falling edge. A mid-slot memory change queues the unchanged codes for the very next edge. A drop of `disp_on` queues all-ground codes one edge later, and so does its return, because driving resumes only at the next refresh. The frame marker is checked on every cycle: it must be 1 exactly on a queued frame-start refresh and 0 on every other cycle.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int LVL_W = 3;

  localparam logic [LVL_W-1:0] LV_GND  = 3'd0;
  localparam logic [LVL_W-1:0] LV_Q1   = 3'd1;
  localparam logic [LVL_W-1:0] LV_HALF = 3'd2;
  localparam logic [LVL_W-1:0] LV_Q3   = 3'd3;
  localparam logic [LVL_W-1:0] LV_FULL = 3'd4;

  // Mirror a level about mid-scale for the inverted frame.
  function automatic logic [LVL_W-1:0] lvl_mirror(input logic [LVL_W-1:0] lv,
                                                  input logic inv);
    return inv ? (LV_FULL - lv) : lv;
  endfunction
endpackage

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing #(
  parameter int NCOM      = 8,
  parameter int SLOT_CLKS = 64,
  localparam int COMW = (NCOM > 1) ? $clog2(NCOM) : 1,
  localparam int PRW  = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            disp_on,
  output logic            slot_start,
  output logic [COMW-1:0] com_idx,
  output logic            inv,
  output logic            frame_start
);
  logic [PRW-1:0]  presc_q, presc_d;
  logic [COMW-1:0] com_q, com_d;
  logic            inv_q, inv_d;
  logic            frame_q, frame_d;
  logic            slot_end, last_com;

  always_comb begin
    slot_end = (presc_q == PRW'(SLOT_CLKS - 1));
    last_com = (com_q == COMW'(NCOM - 1));
    presc_d  = slot_end ? '0 : presc_q + 1'b1;
    com_d    = com_q;
    if (slot_end) com_d = last_com ? '0 : com_q + 1'b1;
    inv_d    = (slot_end && last_com) ? ~inv_q : inv_q;
    frame_d  = (presc_q == '0) && (com_q == '0) && !inv_q && disp_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      com_q   <= '0;
      inv_q   <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      presc_q <= presc_d;
      com_q   <= com_d;
      inv_q   <= inv_d;
      frame_q <= frame_d;
    end
  end

  assign slot_start  = (presc_q == '0);
  assign com_idx     = com_q;
  assign inv         = inv_q;
  assign frame_start = frame_q;

  // R2: the served common moves only across a slot boundary
  p_com_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && (com_q != $past(com_q)) |-> $past(presc_q) == PRW'(SLOT_CLKS - 1));

  // R8: marker lasts one cycle
  p_frame_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_q |=> !frame_q);

  // R8: marker only during the slot of common 0, non-inverted
  p_frame_com0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_q |-> (com_q == '0) && !inv_q && (presc_q == PRW'(1)));
endmodule

// File: rtl/lcd_com_drive.sv
module lcd_com_drive
  import lcd_scan_pkg::*;
#(
  parameter int NCOM = 8,
  localparam int COMW = (NCOM > 1) ? $clog2(NCOM) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  disp_on,
  input  logic                  slot_start,
  input  logic [COMW-1:0]       com_idx,
  input  logic                  inv,
  output logic [NCOM*LVL_W-1:0] com_lvl
);
  logic [NCOM-1:0][LVL_W-1:0] lvl_q, lvl_d;
  logic [NCOM-1:0]            ext;

  for (genvar n = 0; n < NCOM; n++) begin : g_com
    always_comb begin
      lvl_d[n] = lvl_mirror((com_idx == COMW'(n)) ? LV_FULL : LV_Q1, inv);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          lvl_q[n] <= LV_GND;
      else if (!disp_on)   lvl_q[n] <= LV_GND;
      else if (slot_start) lvl_q[n] <= lvl_d[n];
    end

    assign ext[n] = (lvl_q[n] == LV_FULL) || (lvl_q[n] == LV_GND);

    // R3 R6: a loaded common never sits at mid-scale
    p_com_no_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(slot_start && disp_on) |-> lvl_q[n] != LV_HALF);
  end

  assign com_lvl = lvl_q;

  // R3: exactly one common at an extreme level after a refresh
  p_one_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(slot_start && disp_on) |-> $countones(ext) == 1);

  // R7: display off grounds every common
  p_com_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(disp_on) |-> com_lvl == '0);
endmodule

// File: rtl/lcd_seg_drive.sv
module lcd_seg_drive
  import lcd_scan_pkg::*;
#(
  parameter int NCOM = 8,
  parameter int NSEG = 64,
  localparam int COMW = (NCOM > 1) ? $clog2(NCOM) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  disp_on,
  input  logic                  slot_start,
  input  logic [COMW-1:0]       com_idx,
  input  logic                  inv,
  input  logic [NSEG*NCOM-1:0]  seg_cols,
  output logic [NSEG*LVL_W-1:0] seg_lvl
);
  logic [NSEG-1:0][LVL_W-1:0] lvl_q, lvl_d;

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    logic [NCOM-1:0] col;
    logic            pix;

    assign col = seg_cols[k*NCOM +: NCOM];
    assign pix = col[com_idx];

    always_comb begin
      lvl_d[k] = lvl_mirror(pix ? LV_GND : LV_HALF, inv);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          lvl_q[k] <= LV_GND;
      else if (!disp_on)   lvl_q[k] <= LV_GND;
      else if (slot_start) lvl_q[k] <= lvl_d[k];
    end

    // R4 R6: loaded segment uses only ground, half or full
    p_seg_codes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(slot_start && disp_on) |->
        (lvl_q[k] == LV_GND) || (lvl_q[k] == LV_HALF) || (lvl_q[k] == LV_FULL));
  end

  assign seg_lvl = lvl_q;

  // R5: no change to segment drive inside a slot
  p_hold_midslot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(slot_start) && $past(disp_on) |-> $stable(seg_lvl));

  // R7: display off grounds every segment
  p_seg_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(disp_on) |-> seg_lvl == '0);
endmodule

// File: rtl/lcd_mux_scan.sv
module lcd_mux_scan
  import lcd_scan_pkg::*;
#(
  parameter int NCOM      = 8,
  parameter int NSEG      = 64,
  parameter int SLOT_CLKS = 64,
  localparam int COMW = (NCOM > 1) ? $clog2(NCOM) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  disp_on,
  input  logic [NSEG*NCOM-1:0]  seg_cols,
  output logic [NCOM*LVL_W-1:0] com_lvl,
  output logic [NSEG*LVL_W-1:0] seg_lvl,
  output logic                  frame_start
);
  logic            slot_start;
  logic [COMW-1:0] com_idx;
  logic            inv;

  lcd_scan_timing #(.NCOM(NCOM), .SLOT_CLKS(SLOT_CLKS)) timing_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .disp_on     (disp_on),
    .slot_start  (slot_start),
    .com_idx     (com_idx),
    .inv         (inv),
    .frame_start (frame_start)
  );

  lcd_com_drive #(.NCOM(NCOM)) com_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .disp_on    (disp_on),
    .slot_start (slot_start),
    .com_idx    (com_idx),
    .inv        (inv),
    .com_lvl    (com_lvl)
  );

  lcd_seg_drive #(.NCOM(NCOM), .NSEG(NSEG)) seg_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .disp_on    (disp_on),
    .slot_start (slot_start),
    .com_idx    (com_idx),
    .inv        (inv),
    .seg_cols   (seg_cols),
    .seg_lvl    (seg_lvl)
  );

  // R1: outputs quiet right after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (com_lvl == '0) && (seg_lvl == '0) && !frame_start);
endmodule

// File: tb/lcd_mux_scan_tb.sv
`timescale 1ns/1ps
module lcd_mux_scan_tb_top;
  localparam int NC = 8;
  localparam int NS = 64;
  localparam int SL = 64;
  localparam int CW = NC*3;
  localparam int SW = NS*3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          disp_on;
  logic [NS*NC-1:0] seg_cols;
  logic [CW-1:0] com_lvl;
  logic [SW-1:0] seg_lvl;
  logic          frame_start;

  always #2 clk = ~clk;

  lcd_mux_scan dut_i (
    .clk(clk), .rst_n(rst_n), .disp_on(disp_on), .seg_cols(seg_cols),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl), .frame_start(frame_start)
  );

  int ecount = 0;
  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;
  bit on_now;
  logic [CW-1:0] last_com;
  logic [SW-1:0] last_seg;

  int            q_due[$];
  logic [CW-1:0] q_com[$];
  logic [SW-1:0] q_seg[$];
  logic          q_fs[$];
  string         q_tag[$];

  always @(posedge clk) if (rst_n === 1'b1) ecount <= ecount + 1;

  task automatic chk(input bit ok, input string tag,
                     input logic [SW-1:0] act, input logic [SW-1:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input int due, input logic [CW-1:0] c, input logic [SW-1:0] s,
                      input logic f, input string tag);
    q_due.push_back(due); q_com.push_back(c); q_seg.push_back(s);
    q_fs.push_back(f); q_tag.push_back(tag);
  endtask

  // Driver: expected codes for slot s, from the requirements
  task automatic expect_slot(input int s, input int due);
    int c;
    bit i;
    logic [2:0] lv;
    logic [CW-1:0] ce;
    logic [SW-1:0] se;
    c = s % NC;
    i = ((s / NC) % 2) == 1;
    for (int n = 0; n < NC; n++) begin
      lv = (n == c) ? 3'd4 : 3'd1;      // R3
      if (i) lv = 3'd4 - lv;            // R6
      if (!on_now) lv = 3'd0;           // R7
      ce[n*3 +: 3] = lv;
    end
    for (int k = 0; k < NS; k++) begin
      lv = seg_cols[k*NC + c] ? 3'd0 : 3'd2;  // R4
      if (i) lv = 3'd4 - lv;
      if (!on_now) lv = 3'd0;
      se[k*3 +: 3] = lv;
    end
    push(due, ce, se, on_now && (c == 0) && !i, i ? "R2 R6 slot" : "R2 R3 R4 slot");
    last_com = ce;
    last_seg = se;
  endtask

  task automatic expect_hold(input int due, input string tag);
    push(due, last_com, last_seg, 1'b0, tag);
  endtask

  function automatic logic [NS*NC-1:0] pat(input int n);
    logic [NS*NC-1:0] r;
    case (n % 4)
      0: r = '1;
      1: r = '0;
      2: r = {(NS*NC/8){8'hA5}};
      default: for (int w = 0; w < NS*NC/32; w++)
                 r[w*32 +: 32] = 32'h9E3779B9 * (n*64 + w + 1);
    endcase
    return r;
  endfunction

  // Monitor: pop due items and compare; marker checked every cycle (R8)
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      if (q_due.size() > 0 && q_due[0] == ecount) begin
        chk(com_lvl == q_com[0], {q_tag[0], " com"}, SW'(com_lvl), SW'(q_com[0]));
        chk(seg_lvl == q_seg[0], {q_tag[0], " seg"}, seg_lvl, q_seg[0]);
        chk(frame_start == q_fs[0], "R8 marker at refresh", SW'(frame_start), SW'(q_fs[0]));
        void'(q_due.pop_front()); void'(q_com.pop_front()); void'(q_seg.pop_front());
        void'(q_fs.pop_front()); void'(q_tag.pop_front());
      end else begin
        chk(frame_start == 1'b0, "R8 marker idle", SW'(frame_start), '0);
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    disp_on = 1'b1;
    on_now = 1'b1;
    seg_cols = pat(0);
    last_com = '0;
    last_seg = '0;
    repeat (3) @(negedge clk);
    chk(com_lvl == '0, "R1 com reset", SW'(com_lvl), '0);
    chk(seg_lvl == '0, "R1 seg reset", seg_lvl, '0);
    chk(frame_start == 1'b0, "R1 marker reset", SW'(frame_start), '0);
    rst_n = 1'b1;
    expect_slot(0, 1);
    for (int e = 1; e <= 4160; e++) begin
      @(negedge clk);
      if (e == 1900) begin
        disp_on = 1'b0; on_now = 1'b0;
        last_com = '0; last_seg = '0;
        expect_hold(e + 1, "R7 off");
      end
      if (e == 2100) begin
        disp_on = 1'b1; on_now = 1'b1;
        expect_hold(e + 1, "R7 resume waits");
      end
      if ((e % SL) == SL/2 && on_now) begin
        seg_cols = pat(e / SL + 1);
        expect_hold(e + 1, "R5 hold");
      end
      if ((e % SL) == 0) expect_slot(e / SL, e + 1);
    end
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule